// File: doc/BRIEF.md
# Block Transfer Data Buffer

This block is a word-organized data store that sits between a host register bus and the byte engine of a serial bus controller. It lets one transaction carry up to 1024 bytes, instead of splitting the data into many short transactions of at most 8 bytes. The host sees four 64-bit registers:

- a mode word, which holds the block-enable flag;
- a length register;
- a status register, with a pointer-reset action and a completion flag;
- a data window into the store.

The engine sees a byte stream. For an outbound transfer it pops bytes through a valid/ready handshake. For an inbound transfer it pushes bytes through a second valid/ready handshake. A shared index tracks how far the transfer has progressed.

Bytes are packed big-endian into the 64-bit words: the first byte of a transfer is the most significant byte of word zero. For an outbound transfer, software resets the pointer, fills the store and then starts the controller. For an inbound transfer, software waits for completion, resets the pointer and then drains the words. The length register takes the byte count minus one.

Top module: `blk_xfer_buf`

## Requirements
- R1: After reset, the mode and length registers read 0, done_o is 0, and both tx_valid_o and rx_ready_o are 0.
- R2: The mode register (offset 0x1038) keeps only bits 0, 2 and 4 of a write. All other bits read 0. Bit 2 is the block-enable flag.
- R3: The length register (offset 0x1048) holds the byte count minus one, in 10 bits. done_o rises after exactly length+1 engine byte transfers.
- R4: Transfer byte k sits in word k/8 of the data window (offset 0x1058), at bits 63-8*(k%8) down to 56-8*(k%8). This holds for host words and for engine bytes alike.
- R5: Each host read or write of the data window advances the host word pointer by one.
- R6: Writing 1 to bit 0 of the status register (offset 0x1050) returns the host word pointer and the engine byte index to zero and clears done_o.
- R7: While done_o is 1, tx_valid_o and rx_ready_o stay 0 until the next pointer reset.
- R8: A host read of the window at a word past the last word of the transfer returns 0. In the last word, bytes past the transfer length read as 0.
- R9: With the block-enable flag clear, tx_valid_o and rx_ready_o are 0.
- R10: dir_rd_i = 0 selects the outbound channel (tx_valid_o may be asserted). dir_rd_i = 1 selects the inbound channel (rx_ready_o may be asserted). The other channel is held idle.
- R11: Bit 1 of the status register reads the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 16 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (advances the window pointer) |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i (combinational) |
| dir_rd_i | input | 1 | Engine direction, 1 = inbound |
| tx_byte_o | output | 8 | Byte offered to the engine |
| tx_valid_o | output | 1 | tx_byte_o is available |
| tx_ready_i | input | 1 | Engine takes tx_byte_o |
| rx_byte_i | input | 8 | Byte delivered by the engine |
| rx_valid_i | input | 1 | rx_byte_i is valid |
| rx_ready_o | output | 1 | Buffer accepts rx_byte_i |
| done_o | output | 1 | length+1 bytes transferred |

## Verification
The assertions check properties that must hold on every cycle:

- the engine handshakes stay idle while block mode is off, and once done is reached;
- only the channel chosen by the direction input is ever active;
- every accepted byte advances the engine index by exactly one;
- a pointer reset always clears done.

The bench scenarios show what a single-cycle property cannot:

- the big-endian byte order across words;
- the count-minus-one length rule, including the full 1024-byte case;
- zero masking of the partial last word and of words past it;
- a transfer that restarts from byte zero after a mid-stream pointer reset.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int unsigned REG_AW = 16;
  localparam int unsigned REG_DW = 64;

  localparam logic [REG_AW-1:0] OFS_MODE = 16'h1038;
  localparam logic [REG_AW-1:0] OFS_LEN  = 16'h1048;
  localparam logic [REG_AW-1:0] OFS_STS  = 16'h1050;
  localparam logic [REG_AW-1:0] OFS_WIN  = 16'h1058;

  localparam int unsigned MODE_HS_BIT  = 0;
  localparam int unsigned MODE_BLK_BIT = 2;
  localparam int unsigned MODE_REF_BIT = 4;
  localparam logic [REG_DW-1:0] MODE_KEEP =
    (REG_DW'(1) << MODE_HS_BIT) | (REG_DW'(1) << MODE_BLK_BIT) | (REG_DW'(1) << MODE_REF_BIT);

  localparam int unsigned STS_PRST_BIT = 0;
  localparam int unsigned STS_DONE_BIT = 1;
endpackage

// File: rtl/blk_regs.sv
module blk_regs
  import blk_xfer_pkg::*;
#(
  parameter int unsigned LEN_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] mode_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              blk_en_o,
  output logic              ptr_rst_o
);
  logic [REG_DW-1:0] mode_q;
  logic [LEN_W-1:0]  len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      len_q  <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_MODE) mode_q <= wdata_i & MODE_KEEP;
      if (addr_i == OFS_LEN)  len_q  <= wdata_i[LEN_W-1:0];
    end
  end

  assign mode_o    = mode_q;
  assign len_o     = len_q;
  assign blk_en_o  = mode_q[MODE_BLK_BIT];
  assign ptr_rst_o = we_i && (addr_i == OFS_STS) && wdata_i[STS_PRST_BIT];
endmodule

// File: rtl/blk_store.sv
module blk_store
  import blk_xfer_pkg::*;
#(
  parameter int unsigned WORDS = 128,
  parameter int unsigned LEN_W = 10,
  localparam int unsigned WPTR_W = $clog2(WORDS) + 1,
  localparam int unsigned IDX_W  = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [REG_DW-1:0] host_wdata_i,
  input  logic              ptr_rst_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              eng_wr_i,
  input  logic [IDX_W-1:0]  eng_idx_i,
  input  logic [7:0]        eng_wbyte_i,
  output logic [7:0]        eng_rbyte_o,
  output logic [REG_DW-1:0] win_rdata_o
);
  logic [REG_DW-1:0] mem [WORDS];
  logic [WPTR_W-1:0] host_ptr;
  logic              ptr_in_range;
  logic [WPTR_W-1:0] last_word;
  logic [LEN_W-4:0]  eng_word;
  logic [REG_DW-1:0] raw_word;
  logic [REG_DW-1:0] lane_keep;
  logic              is_last;

  assign ptr_in_range = host_ptr < WPTR_W'(WORDS);
  assign last_word    = WPTR_W'(len_i[LEN_W-1:3]);
  assign eng_word     = eng_idx_i[LEN_W-1:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_ptr <= '0;
    else if (ptr_rst_i) host_ptr <= '0;
    else if ((host_wr_i || host_rd_i) && ptr_in_range) host_ptr <= host_ptr + 1'b1;
  end

  // host word write has priority over an engine byte in the same cycle
  always_ff @(posedge clk_i) begin
    if (host_wr_i && ptr_in_range)
      mem[host_ptr[WPTR_W-2:0]] <= host_wdata_i;
    else if (eng_wr_i)
      mem[eng_word][{~eng_idx_i[2:0], 3'b000} +: 8] <= eng_wbyte_i;
  end

  assign eng_rbyte_o = mem[eng_word][{~eng_idx_i[2:0], 3'b000} +: 8];

  assign raw_word = ptr_in_range ? mem[host_ptr[WPTR_W-2:0]] : '0;
  assign is_last  = host_ptr == last_word;

  for (genvar g = 0; g < 8; g++) begin : g_lane
    assign lane_keep[REG_DW-1-8*g -: 8] = (!is_last || (3'(g) <= len_i[2:0])) ? 8'hFF : 8'h00;
  end

  assign win_rdata_o = (ptr_in_range && host_ptr <= last_word) ? (raw_word & lane_keep) : '0;
endmodule

// File: rtl/blk_eng.sv
module blk_eng #(
  parameter int unsigned LEN_W = 10,
  localparam int unsigned IDX_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blk_en_i,
  input  logic             dir_rd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ptr_rst_i,
  input  logic             tx_ready_i,
  input  logic             rx_valid_i,
  output logic             tx_valid_o,
  output logic             rx_ready_o,
  output logic             eng_wr_o,
  output logic             fire_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  logic [IDX_W-1:0] idx_q;
  logic             active;

  assign done_o     = idx_q == ({1'b0, len_i} + IDX_W'(1));
  assign active     = blk_en_i && !done_o;
  assign tx_valid_o = active && !dir_rd_i;
  assign rx_ready_o = active && dir_rd_i;
  assign eng_wr_o   = rx_ready_o && rx_valid_i;
  assign fire_o     = (tx_valid_o && tx_ready_i) || eng_wr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (ptr_rst_i) idx_q <= '0;
    else if (fire_o) idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/blk_xfer_buf.sv
module blk_xfer_buf
  import blk_xfer_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 1024,
  localparam int unsigned WORDS = MAX_BYTES / 8,
  localparam int unsigned LEN_W = $clog2(MAX_BYTES),
  localparam int unsigned IDX_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              dir_rd_i,
  output logic [7:0]        tx_byte_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic              done_o
);
  logic [REG_DW-1:0] mode_q;
  logic [LEN_W-1:0]  len_q;
  logic              blk_en;
  logic              ptr_rst;
  logic              eng_wr;
  logic              fire;
  logic [IDX_W-1:0]  eng_idx;
  logic [REG_DW-1:0] win_rdata;
  logic              win_sel;

  assign win_sel = reg_addr_i == OFS_WIN;

  blk_regs #(.LEN_W(LEN_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .mode_o   (mode_q),
    .len_o    (len_q),
    .blk_en_o (blk_en),
    .ptr_rst_o(ptr_rst)
  );

  blk_eng #(.LEN_W(LEN_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .blk_en_i  (blk_en),
    .dir_rd_i  (dir_rd_i),
    .len_i     (len_q),
    .ptr_rst_i (ptr_rst),
    .tx_ready_i(tx_ready_i),
    .rx_valid_i(rx_valid_i),
    .tx_valid_o(tx_valid_o),
    .rx_ready_o(rx_ready_o),
    .eng_wr_o  (eng_wr),
    .fire_o    (fire),
    .idx_o     (eng_idx),
    .done_o    (done_o)
  );

  blk_store #(.WORDS(WORDS), .LEN_W(LEN_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_wr_i   (reg_we_i && win_sel),
    .host_rd_i   (reg_re_i && win_sel),
    .host_wdata_i(reg_wdata_i),
    .ptr_rst_i   (ptr_rst),
    .len_i       (len_q),
    .eng_wr_i    (eng_wr),
    .eng_idx_i   (eng_idx),
    .eng_wbyte_i (rx_byte_i),
    .eng_rbyte_o (tx_byte_o),
    .win_rdata_o (win_rdata)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_MODE: reg_rdata_o = mode_q;
      OFS_LEN:  reg_rdata_o = REG_DW'(len_q);
      OFS_STS:  reg_rdata_o = REG_DW'(done_o) << STS_DONE_BIT;
      OFS_WIN:  reg_rdata_o = win_rdata;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/blk_xfer_buf_chk.sv
module blk_xfer_buf_chk #(
  parameter int unsigned IDX_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blk_en,
  input logic             dir_rd_i,
  input logic             tx_valid_o,
  input logic             rx_ready_o,
  input logic             done_o,
  input logic             ptr_rst,
  input logic             fire,
  input logic [IDX_W-1:0] eng_idx
);
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!tx_valid_o && !rx_ready_o)); // R7

  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_en |-> (!tx_valid_o && !rx_ready_o)); // R9

  AST_TX_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !dir_rd_i); // R10

  AST_RX_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> dir_rd_i); // R10

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !ptr_rst) |=> (eng_idx == $past(eng_idx) + IDX_W'(1))); // R3

  AST_PRST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst |=> (!done_o && eng_idx == '0)); // R6
endmodule

bind blk_xfer_buf blk_xfer_buf_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .blk_en    (blk_en),
  .dir_rd_i  (dir_rd_i),
  .tx_valid_o(tx_valid_o),
  .rx_ready_o(rx_ready_o),
  .done_o    (done_o),
  .ptr_rst   (ptr_rst),
  .fire      (fire),
  .eng_idx   (eng_idx)
);

// File: tb/blk_xfer_buf_bench.sv
`timescale 1ns/1ps
module blk_xfer_buf_bench;
  localparam logic [15:0] A_MODE = 16'h1038;
  localparam logic [15:0] A_LEN  = 16'h1048;
  localparam logic [15:0] A_STS  = 16'h1050;
  localparam logic [15:0] A_WIN  = 16'h1058;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [63:0] wdata = '0, rdata;
  logic        dir_rd = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        done;

  int total = 0, bad = 0, pops = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  blk_xfer_buf u_blk_xfer_buf (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .dir_rd_i(dir_rd),
    .tx_byte_o(tx_byte), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_byte_i(rx_byte), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(k * 37 + seed * 11 + 5);
  endfunction

  // big-endian packing: byte k of word w at bits 63-8b
  function automatic logic [63:0] pack(input int seed, input int w, input int n);
    logic [63:0] v = '0;
    for (int b = 0; b < 8; b++)
      if (8 * w + b < n) v[63 - 8 * b -: 8] = pat(seed, 8 * w + b);
    return v;
  endfunction

  task automatic reg_wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic push_exp(input int seed, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(pat(seed, k));
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
  endtask

  // monitor: compare each popped byte against the scoreboard
  always @(negedge clk) begin
    #1;
    if (tx_valid && tx_ready) begin
      pops++;
      if (exp_q.size() == 0) chk(1'b0, "R4 pop on empty queue", 64'(tx_byte), 64'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_byte == e, "R4 tx byte order", 64'(tx_byte), 64'(e));
      end
    end
  end

  initial begin
    #400000;
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(A_MODE, v); chk(v == 0, "R1 mode", v, 0);
    reg_rd(A_LEN, v);  chk(v == 0, "R1 len", v, 0);
    chk({done, tx_valid, rx_ready} == 3'b000, "R1 outputs", 64'({done, tx_valid, rx_ready}), 0);

    // R2 mode masking; R9 disabled
    reg_wr(A_MODE, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_rd(A_MODE, v); chk(v == 64'h15, "R2 mode keep", v, 64'h15);
    reg_wr(A_LEN, 64'd12);
    reg_wr(A_MODE, 64'h11);
    #1 chk(!tx_valid && !rx_ready, "R9 off idle", 64'({tx_valid, rx_ready}), 0);
    reg_wr(A_MODE, 64'h15);
    reg_rd(A_MODE, v); chk(v == 64'h15, "R2 restore", v, 64'h15);

    // outbound 13 bytes, word 1 fully loaded to expose masking
    reg_wr(A_STS, 64'h1);
    reg_wr(A_WIN, pack(1, 0, 16));
    reg_wr(A_WIN, pack(1, 1, 16));
    reg_wr(A_STS, 64'h1);
    #1 chk(tx_valid && !rx_ready, "R10 tx channel", 64'({tx_valid, rx_ready}), 64'b10);
    pops = 0; push_exp(1, 13);
    @(negedge clk); tx_ready = 1'b1;
    wait_done();
    tx_ready = 1'b0;
    chk(pops == 13, "R3 count minus one", 64'(pops), 13);
    chk(done, "R3 done", 64'(done), 1);
    #1 chk(!tx_valid, "R7 refuse after done", 64'(tx_valid), 0);
    reg_rd(A_STS, v); chk(v[1] == 1'b1, "R11 done bit", v, 64'h2);
    reg_wr(A_STS, 64'h1);
    chk(!done, "R6 clears done", 64'(done), 0);
    reg_rd(A_WIN, v); chk(v == pack(1, 0, 13), "R5 word0", v, pack(1, 0, 13));
    reg_rd(A_WIN, v); chk(v == pack(1, 1, 13), "R8 partial word", v, pack(1, 1, 13));
    reg_rd(A_WIN, v); chk(v == 64'h0, "R8 past last", v, 0);

    // inbound 20 bytes
    reg_wr(A_LEN, 64'd19);
    reg_wr(A_STS, 64'h1);
    dir_rd = 1'b1;
    #1 chk(rx_ready && !tx_valid, "R10 rx channel", 64'({tx_valid, rx_ready}), 64'b01);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); rx_valid = 1'b1; rx_byte = pat(2, k);
    end
    @(negedge clk); rx_valid = 1'b0;
    chk(done, "R3 rx done", 64'(done), 1);
    #1 chk(!rx_ready, "R7 rx refuse", 64'(rx_ready), 0);
    reg_wr(A_STS, 64'h1);
    for (int w = 0; w < 4; w++) begin
      reg_rd(A_WIN, v); chk(v == pack(2, w, 20), "R4 rx packing", v, pack(2, w, 20));
    end
    dir_rd = 1'b0;

    // R6 mid-transfer restart
    reg_wr(A_LEN, 64'd15);
    reg_wr(A_STS, 64'h1);
    reg_wr(A_WIN, pack(3, 0, 16));
    reg_wr(A_WIN, pack(3, 1, 16));
    reg_wr(A_STS, 64'h1);
    pops = 0; push_exp(3, 16);
    @(negedge clk); tx_ready = 1'b1;
    repeat (5) @(negedge clk);
    tx_ready = 1'b0;
    exp_q.delete();
    reg_wr(A_STS, 64'h1);
    chk(!done && pops == 5, "R6 partial", 64'(pops), 5);
    pops = 0; push_exp(3, 16);
    @(negedge clk); tx_ready = 1'b1;
    wait_done();
    tx_ready = 1'b0;
    chk(pops == 16, "R6 restart from zero", 64'(pops), 16);

    // full 1024-byte transfer
    reg_wr(A_LEN, 64'd1023);
    reg_wr(A_STS, 64'h1);
    for (int w = 0; w < 128; w++) reg_wr(A_WIN, pack(4, w, 1024));
    reg_wr(A_WIN, 64'hDEAD);
    reg_wr(A_STS, 64'h1);
    pops = 0; push_exp(4, 1024);
    @(negedge clk); tx_ready = 1'b1;
    wait_done();
    tx_ready = 1'b0;
    chk(pops == 1024 && done, "R3 max length", 64'(pops), 1024);
    reg_rd(A_LEN, v); chk(v == 64'd1023, "R3 len readback", v, 1023);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule